// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small bank of platform control registers reached over a simple synchronous bus. It holds an 8-bit configuration register and two 8-bit auxiliary registers. It also holds an 8-bit diagnostic register, an 8-bit modem control register, a 16-bit LED register and a 32-bit system control register. Software uses it to do three things: enable and acknowledge a power-fail interrupt, request power-off or a system reset, and halt the CPU by writing a dedicated power-management address. Each request leaves the block as a single-cycle registered pulse. Whatever consumes the pulse does the actual switching, sequencing or halting.

The bus carries no stream data and has no back-pressure. An access is presented for one cycle with `bus_en` high, and it always completes in that cycle. A write takes effect at that clock edge. Read data appears on `bus_rdata` one cycle later and holds until the next read. Decoding uses only the address bits selected by a mask. The block has two resets. `rst_n` is the asynchronous power-on reset and clears everything. `soft_rst` is a synchronous soft reset. It clears config, aux1, aux2 and modem control, and it leaves diagnostic, LED and system control untouched.

Top module: `aux_sysctl_regs`

## Requirements
- R1: Byte registers are selected by `(bus_addr & 0x0fff0000)` at these offsets: config 0x01800000, aux1 0x01900000, diagnostic 0x01a00000, modem 0x01b00000. A byte access (size 0) writes bits 7:0 of the write data. A read returns the value zero-extended on `bus_rdata` in the cycle after the access.
- R2: On a write, aux2 (offset 0x01910000) stores only write bit 0 (power-off), and all other write bits are discarded. The power-fail status (read bit 5) is kept, unless write bit 1 is one, in which case the status is cleared. Bit 1 itself always reads zero.
- R3: Whenever `pwr_fail` changes, the power-fail status takes the value `pwr_fail AND config bit 3` at the next edge. Without a change of the input, only an aux2 clear or a reset alters the status.
- R4: `irq` is high exactly when the power-fail status and config bit 3 are both one.
- R5: An aux2 write whose bit 0 is one raises `pwroff_req` for the single cycle after the write.
- R6: System control is at offset 0x01f00000 and accepts word accesses (size 2) only. A write to byte offset 0 with bit 0 set loads the value 0x2 and raises `sysrst_req` for one cycle. Other writes leave it unchanged. Reads of byte offsets 1 to 3 return zero.
- R7: The LED register is at offset 0x01600000 and accepts halfword accesses (size 1) only. Offset 0 reads and writes all 16 bits. Offset 1 reads zero and ignores writes.
- R8: A byte write whose full address equals parameter `PM_ADDR` raises `halt_req` for one cycle. A read of that address returns zero.
- R9: `soft_rst` clears config, aux1, aux2 (including the status) and modem control. Diagnostic, LED and system control keep their values.
- R10: Writes to unmapped addresses, and accesses whose size differs from the target's width, change nothing and raise no request. Reads of them return zero.
- R11: `rst_n` low clears every register, including those that survive a soft reset, and holds all request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pwr_fail | input | 1 | Power-fail indication, synchronous level |
| irq | output | 1 | Power-fail interrupt |
| pwroff_req | output | 1 | Power-off request pulse |
| sysrst_req | output | 1 | System reset request pulse |
| halt_req | output | 1 | CPU halt request pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit address, decode mask 0x0fff0000 and `PM_ADDR` 0x7a000004. Every register access goes through base 0x70000000. Its top nibble lies outside the mask, so aliasing through the mask is exercised on every access. The power-management address falls in a masked slot that holds no register, so the halt decode is checked, and reads of the neighbouring masked slot must return zero. The power-fail sequence toggles the input with the enable both set and cleared, which covers the sticky status, its write-one clear and an enable change while the status is pending.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_CFG,
    TGT_AUX1,
    TGT_AUX2,
    TGT_DIAG,
    TGT_MDM,
    TGT_LED,
    TGT_SYS,
    TGT_PM
  } tgt_e;

  localparam logic [31:0] OFS_LED  = 32'h0160_0000;
  localparam logic [31:0] OFS_CFG  = 32'h0180_0000;
  localparam logic [31:0] OFS_AUX1 = 32'h0190_0000;
  localparam logic [31:0] OFS_AUX2 = 32'h0191_0000;
  localparam logic [31:0] OFS_DIAG = 32'h01a0_0000;
  localparam logic [31:0] OFS_MDM  = 32'h01b0_0000;
  localparam logic [31:0] OFS_SYS  = 32'h01f0_0000;

  localparam int CFG_IRQEN_BIT = 3;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int SYS_GO_BIT    = 0;

  localparam logic [31:0] SYS_RST_STAT = 32'h0000_0002;

  localparam int BYTE_W  = 8;
  localparam int LED_W   = 16;
  localparam int WORD_W  = 32;

  // scratch byte registers kept in one generated bank
  localparam int NUM_SCR  = 3;
  localparam int SCR_AUX1 = 0;
  localparam int SCR_DIAG = 1;
  localparam int SCR_MDM  = 2;

endpackage

// File: rtl/aux_ctl_decode.sv
module aux_ctl_decode
  import aux_ctl_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [31:0]     DEC_MASK = 32'h0fff_0000,
  parameter logic [31:0]     PM_ADDR  = 32'h7a00_0004
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output tgt_e              tgt,
  output logic              sub0
);

  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(DEC_MASK);
  localparam logic [ADDR_W-1:0] PM_A   = ADDR_W'(PM_ADDR);

  logic [ADDR_W-1:0] masked;
  tgt_e              raw;
  acc_size_e         need;

  assign masked = addr & MASK_A;

  always_comb begin
    raw  = TGT_NONE;
    need = SZ_BYTE;
    if      (masked == ADDR_W'(OFS_CFG))  raw = TGT_CFG;
    else if (masked == ADDR_W'(OFS_AUX1)) raw = TGT_AUX1;
    else if (masked == ADDR_W'(OFS_AUX2)) raw = TGT_AUX2;
    else if (masked == ADDR_W'(OFS_DIAG)) raw = TGT_DIAG;
    else if (masked == ADDR_W'(OFS_MDM))  raw = TGT_MDM;
    else if (masked == ADDR_W'(OFS_LED))  begin raw = TGT_LED; need = SZ_HALF; end
    else if (masked == ADDR_W'(OFS_SYS))  begin raw = TGT_SYS; need = SZ_WORD; end
    else if (addr == PM_A)                raw = TGT_PM;
  end

  // size mismatch hides the target entirely
  assign tgt = (raw != TGT_NONE && size == need) ? raw : TGT_NONE;

  always_comb begin
    case (tgt)
      TGT_LED: sub0 = (addr[0] == 1'b0);
      TGT_SYS: sub0 = (addr[1:0] == 2'b00);
      default: sub0 = 1'b1;
    endcase
  end

endmodule

// File: rtl/aux_ctl_pwr.sv
module aux_ctl_pwr
  import aux_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_cfg,
  input  logic              wr_aux2,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pf_in,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] aux2_q,
  output logic              irq,
  output logic              pwroff_req
);

  logic pf_prev;
  logic pf_stat;
  logic off_bit;
  logic pf_evt;

  assign pf_evt = (pf_in != pf_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      pf_prev    <= 1'b0;
      pf_stat    <= 1'b0;
      off_bit    <= 1'b0;
      pwroff_req <= 1'b0;
    end else begin
      pf_prev    <= pf_in;
      pwroff_req <= wr_aux2 & wdata[AUX2_OFF_BIT];
      if (soft_rst) begin
        cfg_q   <= '0;
        pf_stat <= 1'b0;
        off_bit <= 1'b0;
      end else begin
        if (wr_cfg) cfg_q <= wdata;
        if (wr_aux2) begin
          off_bit <= wdata[AUX2_OFF_BIT];
          if (wdata[AUX2_CLR_BIT]) pf_stat <= 1'b0;
        end
        if (pf_evt) pf_stat <= pf_in & cfg_q[CFG_IRQEN_BIT];
      end
    end
  end

  always_comb begin
    aux2_q               = '0;
    aux2_q[AUX2_OFF_BIT] = off_bit;
    aux2_q[AUX2_PF_BIT]  = pf_stat;
  end

  assign irq = pf_stat & cfg_q[CFG_IRQEN_BIT];

  // R3: status only rises from an input change seen with the enable set
  p_pf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_stat) |-> ($past(pf_in) && $past(cfg_q[CFG_IRQEN_BIT])));

  // R2: a clear write with no concurrent input change leaves status low
  p_pf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_aux2) && $past(wdata[AUX2_CLR_BIT]) && $past(!pf_evt)) |-> !pf_stat);

  // R4: the interrupt only rises after a config write or an input change
  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wr_cfg) || $past(pf_evt)));

  // R5: every power-off pulse is backed by an aux2 write
  p_off_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |-> $past(wr_aux2));

  // R9: soft reset leaves config and aux2 cleared
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (cfg_q == '0 && aux2_q == '0));

endmodule

// File: rtl/aux_ctl_store.sv
module aux_ctl_store
  import aux_ctl_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            soft_rst,
  input  logic [NUM_SCR-1:0]              wr_scr,
  input  logic                            wr_led,
  input  logic                            wr_sys,
  input  logic                            wr_pm,
  input  logic [LED_W-1:0]                wdata,
  output logic [NUM_SCR-1:0][BYTE_W-1:0]  scr_q,
  output logic [LED_W-1:0]                led_q,
  output logic [WORD_W-1:0]               sys_q,
  output logic                            sysrst_req,
  output logic                            halt_req
);

  // which scratch registers a soft reset clears: aux1 and modem, not diag
  localparam logic [NUM_SCR-1:0] SOFT_CLR =
    (NUM_SCR'(1) << SCR_AUX1) | (NUM_SCR'(1) << SCR_MDM);

  logic sys_go;
  assign sys_go = wr_sys & wdata[SYS_GO_BIT];

  for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
    if (SOFT_CLR[i]) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        scr_q[i] <= '0;
        else if (soft_rst) scr_q[i] <= '0;
        else if (wr_scr[i]) scr_q[i] <= wdata[BYTE_W-1:0];
      end
    end else begin : g_keep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         scr_q[i] <= '0;
        else if (wr_scr[i]) scr_q[i] <= wdata[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q      <= '0;
      sys_q      <= '0;
      sysrst_req <= 1'b0;
      halt_req   <= 1'b0;
    end else begin
      sysrst_req <= sys_go;
      halt_req   <= wr_pm;
      if (wr_led) led_q <= wdata;
      if (sys_go) sys_q <= SYS_RST_STAT;
    end
  end

  // R6: system control only ever holds zero or the reset-status value
  p_sys_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q == '0) || (sys_q == SYS_RST_STAT));

  // R6: a reset request pulse coincides with the status value being visible
  p_sysrst_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_req |-> (sys_q == SYS_RST_STAT));

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_ctl_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] DEC_MASK = 32'h0fff_0000,
  parameter logic [31:0] PM_ADDR  = 32'h7a00_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pwr_fail,
  output logic              irq,
  output logic              pwroff_req,
  output logic              sysrst_req,
  output logic              halt_req
);

  tgt_e                           tgt;
  logic                           sub0;
  logic                           wr;
  logic [NUM_SCR-1:0]             wr_scr;
  logic [BYTE_W-1:0]              cfg_q;
  logic [BYTE_W-1:0]              aux2_q;
  logic [NUM_SCR-1:0][BYTE_W-1:0] scr_q;
  logic [LED_W-1:0]               led_q;
  logic [WORD_W-1:0]              sys_q;
  logic [31:0]                    rd_mux;
  logic                           unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:LED_W];

  aux_ctl_decode #(
    .ADDR_W  (ADDR_W),
    .DEC_MASK(DEC_MASK),
    .PM_ADDR (PM_ADDR)
  ) u_dec (
    .addr(bus_addr),
    .size(bus_size),
    .tgt (tgt),
    .sub0(sub0)
  );

  assign wr = bus_en & bus_we;

  always_comb begin
    wr_scr           = '0;
    wr_scr[SCR_AUX1] = wr && (tgt == TGT_AUX1);
    wr_scr[SCR_DIAG] = wr && (tgt == TGT_DIAG);
    wr_scr[SCR_MDM]  = wr && (tgt == TGT_MDM);
  end

  aux_ctl_pwr u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_cfg    (wr && (tgt == TGT_CFG)),
    .wr_aux2   (wr && (tgt == TGT_AUX2)),
    .wdata     (bus_wdata[BYTE_W-1:0]),
    .pf_in     (pwr_fail),
    .cfg_q     (cfg_q),
    .aux2_q    (aux2_q),
    .irq       (irq),
    .pwroff_req(pwroff_req)
  );

  aux_ctl_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_scr    (wr_scr),
    .wr_led    (wr && (tgt == TGT_LED) && sub0),
    .wr_sys    (wr && (tgt == TGT_SYS) && sub0),
    .wr_pm     (wr && (tgt == TGT_PM)),
    .wdata     (bus_wdata[LED_W-1:0]),
    .scr_q     (scr_q),
    .led_q     (led_q),
    .sys_q     (sys_q),
    .sysrst_req(sysrst_req),
    .halt_req  (halt_req)
  );

  always_comb begin
    rd_mux = '0;
    case (tgt)
      TGT_CFG:  rd_mux = 32'(cfg_q);
      TGT_AUX1: rd_mux = 32'(scr_q[SCR_AUX1]);
      TGT_AUX2: rd_mux = 32'(aux2_q);
      TGT_DIAG: rd_mux = 32'(scr_q[SCR_DIAG]);
      TGT_MDM:  rd_mux = 32'(scr_q[SCR_MDM]);
      TGT_LED:  rd_mux = sub0 ? 32'(led_q) : '0;
      TGT_SYS:  rd_mux = sub0 ? sys_q : '0;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_mux;
  end

  // R8: every halt pulse follows a write to the power-management address
  p_halt_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_en && bus_we && bus_addr == ADDR_W'(PM_ADDR)));

  // R10: a read that mismatches size returns zero
  p_size_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_en && !bus_we) && $past(tgt == TGT_NONE)) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_aux_sysctl_regs.sv
module tb_aux_sysctl_regs;

  localparam logic [31:0] BASE = 32'h7000_0000;
  localparam logic [31:0] A_CFG  = BASE + 32'h0180_0000;
  localparam logic [31:0] A_AUX1 = BASE + 32'h0190_0000;
  localparam logic [31:0] A_AUX2 = BASE + 32'h0191_0000;
  localparam logic [31:0] A_DIAG = BASE + 32'h01a0_0000;
  localparam logic [31:0] A_MDM  = BASE + 32'h01b0_0000;
  localparam logic [31:0] A_LED  = BASE + 32'h0160_0000;
  localparam logic [31:0] A_SYS  = BASE + 32'h01f0_0000;
  localparam logic [31:0] A_PM   = 32'h7a00_0004;
  localparam logic [31:0] A_GAP  = BASE + 32'h01c0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_fail = 1'b0;
  logic        irq, pwroff_req, sysrst_req, halt_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  aux_sysctl_regs dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_fail(pwr_fail), .irq(irq), .pwroff_req(pwroff_req),
    .sysrst_req(sysrst_req), .halt_req(halt_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [31:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_size = sz; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] exp);
    logic [31:0] v;
    rd(sz, a, v);
    check(tag, v, exp);
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R11 irq after reset", 32'(irq), 0);
    check("R11 pulses after reset", {29'd0, pwroff_req, sysrst_req, halt_req}, 0);
    rd_chk("R11 cfg reset", 2'd0, A_CFG, 0);
    rd_chk("R11 led reset", 2'd1, A_LED, 0);
    rd_chk("R11 sys reset", 2'd2, A_SYS, 0);
  endtask

  task automatic t_byte_regs();
    wr(2'd0, A_CFG,  32'hFFFF_FFA5);
    wr(2'd0, A_AUX1, 32'h0000_003C);
    wr(2'd0, A_DIAG, 32'h0000_00C3);
    wr(2'd0, A_MDM,  32'h1234_5696);
    rd_chk("R1 cfg",  2'd0, A_CFG,  32'hA5);
    rd_chk("R1 aux1", 2'd0, A_AUX1, 32'h3C);
    rd_chk("R1 diag", 2'd0, A_DIAG, 32'hC3);
    rd_chk("R1 mdm",  2'd0, A_MDM,  32'h96);
    wr(2'd0, A_CFG, 32'h0);
  endtask

  task automatic t_aux2_poweroff();
    wr(2'd0, A_AUX2, 32'hFE);
    check("R5 no pulse bit0 clear", 32'(pwroff_req), 0);
    rd_chk("R2 aux2 only bit0 kept", 2'd0, A_AUX2, 32'h00);
    wr(2'd0, A_AUX2, 32'h01);
    check("R5 poweroff pulse", 32'(pwroff_req), 1);
    @(negedge clk);
    check("R5 poweroff one cycle", 32'(pwroff_req), 0);
    rd_chk("R2 aux2 bit0 stored", 2'd0, A_AUX2, 32'h01);
    wr(2'd0, A_AUX2, 32'hDC);
    rd_chk("R2 aux2 bit0 cleared", 2'd0, A_AUX2, 32'h00);
  endtask

  task automatic t_power_fail();
    wr(2'd0, A_CFG, 32'h08);
    pwr_fail = 1'b1;
    @(negedge clk);
    check("R4 irq on pf with enable", 32'(irq), 1);
    rd_chk("R3 status set", 2'd0, A_AUX2, 32'h20);
    wr(2'd0, A_AUX2, 32'h00);
    rd_chk("R2 status kept on write", 2'd0, A_AUX2, 32'h20);
    check("R4 irq kept", 32'(irq), 1);
    wr(2'd0, A_AUX2, 32'h02);
    rd_chk("R2 clear drops status", 2'd0, A_AUX2, 32'h00);
    check("R4 irq low after clear", 32'(irq), 0);
    repeat (2) @(negedge clk);
    check("R3 no retrigger on steady input", 32'(irq), 0);
    pwr_fail = 1'b0;
    @(negedge clk);
    pwr_fail = 1'b1;
    @(negedge clk);
    check("R3 retrigger on new edge", 32'(irq), 1);
    wr(2'd0, A_CFG, 32'h00);
    check("R4 irq gated by enable", 32'(irq), 0);
    rd_chk("R3 status survives enable drop", 2'd0, A_AUX2, 32'h20);
    wr(2'd0, A_CFG, 32'h08);
    check("R4 irq back with enable", 32'(irq), 1);
    pwr_fail = 1'b0;
    @(negedge clk);
    check("R3 status cleared on input fall", 32'(irq), 0);
    wr(2'd0, A_CFG, 32'h00);
    pwr_fail = 1'b1;
    @(negedge clk);
    rd_chk("R3 no status without enable", 2'd0, A_AUX2, 32'h00);
    pwr_fail = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sysctrl();
    rd_chk("R6 sys initial", 2'd2, A_SYS, 0);
    wr(2'd2, A_SYS, 32'hFFFF_FFFE);
    check("R6 no pulse bit0 clear", 32'(sysrst_req), 0);
    rd_chk("R6 sys unchanged", 2'd2, A_SYS, 0);
    wr(2'd0, A_SYS, 32'h01);
    check("R10 byte write to sys ignored", 32'(sysrst_req), 0);
    wr(2'd2, A_SYS + 1, 32'h01);
    check("R6 nonzero offset write ignored", 32'(sysrst_req), 0);
    wr(2'd2, A_SYS, 32'hFFFF_FFF1);
    check("R6 reset pulse", 32'(sysrst_req), 1);
    @(negedge clk);
    check("R6 reset pulse one cycle", 32'(sysrst_req), 0);
    rd_chk("R6 sys status", 2'd2, A_SYS, 32'h2);
    for (int k = 1; k < 4; k++) rd_chk("R6 sys high offsets zero", 2'd2, A_SYS + 32'(k), 0);
  endtask

  task automatic t_led();
    wr(2'd1, A_LED, 32'h5555_BEEF);
    rd_chk("R7 led readback", 2'd1, A_LED, 32'hBEEF);
    rd_chk("R7 led offset1 zero", 2'd1, A_LED + 1, 0);
    wr(2'd1, A_LED + 1, 32'h1234);
    wr(2'd0, A_LED, 32'h77);
    rd_chk("R7 led offset1/byte writes ignored", 2'd1, A_LED, 32'hBEEF);
  endtask

  task automatic t_pm();
    wr(2'd0, A_PM, 32'hAA);
    check("R8 halt pulse", 32'(halt_req), 1);
    @(negedge clk);
    check("R8 halt one cycle", 32'(halt_req), 0);
    rd_chk("R8 pm reads zero", 2'd0, A_PM, 0);
    wr(2'd1, A_PM, 32'hAA);
    check("R10 halfword pm ignored", 32'(halt_req), 0);
  endtask

  task automatic t_unmapped();
    wr(2'd0, A_GAP, 32'hFF);
    check("R10 gap write no request", {29'd0, pwroff_req, sysrst_req, halt_req}, 0);
    rd_chk("R10 gap reads zero", 2'd0, A_GAP, 0);
    wr(2'd0, A_CFG, 32'h5A);
    wr(2'd1, A_CFG, 32'h11);
    rd_chk("R10 halfword cfg write ignored", 2'd0, A_CFG, 32'h5A);
    rd_chk("R10 word cfg read zero", 2'd2, A_CFG, 0);
    wr(2'd0, A_CFG, 32'h0);
  endtask

  task automatic t_soft_reset();
    wr(2'd0, A_CFG,  32'h08);
    wr(2'd0, A_AUX1, 32'h11);
    wr(2'd0, A_AUX2, 32'h01);
    wr(2'd0, A_DIAG, 32'h22);
    wr(2'd0, A_MDM,  32'h33);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    rd_chk("R9 cfg cleared",   2'd0, A_CFG,  0);
    rd_chk("R9 aux1 cleared",  2'd0, A_AUX1, 0);
    rd_chk("R9 aux2 cleared",  2'd0, A_AUX2, 0);
    rd_chk("R9 mdm cleared",   2'd0, A_MDM,  0);
    rd_chk("R9 diag kept",     2'd0, A_DIAG, 32'h22);
    rd_chk("R9 led kept",      2'd1, A_LED,  32'hBEEF);
    rd_chk("R9 sys kept",      2'd2, A_SYS,  32'h2);
  endtask

  task automatic t_hard_reset();
    hard_reset();
    rd_chk("R11 diag cleared", 2'd0, A_DIAG, 0);
    rd_chk("R11 led cleared",  2'd1, A_LED,  0);
    rd_chk("R11 sys cleared",  2'd2, A_SYS,  0);
  endtask

  initial begin
    @(negedge clk);
    hard_reset();
    t_reset_state();
    t_byte_regs();
    t_aux2_poweroff();
    t_power_fail();
    t_sysctrl();
    t_led();
    t_pm();
    t_unmapped();
    t_soft_reset();
    t_hard_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule